// File: doc/BRIEF.md
# Step-adaptive moving average filter

This block sits after a first-stage decimator and chooses what the converter reports. In normal operation it forwards the result of a slow-settling FIR path unchanged. When the averaging mode is enabled and an external detector flags a step on the input, the block stops forwarding the FIR result. It reports a moving average of the first-stage samples instead, so a usable value is available long before the FIR path has caught up.

The averaging window starts at two samples. It doubles to four, eight and sixteen as enough post-step samples arrive to fill the larger window, and it stays at sixteen after that. Each average is a running sum shifted right by the log2 of the window length. A steady flag stays low while averages are being reported. Once the FIR path reports that it has settled, the block returns to the FIR result and raises the flag again. A fresh step during averaging restarts the window from two with an empty history.

Top module: `step_avg_filter`

## Requirements
- R1: After reset, `steady` is 1 and `out_data` equals `fir_data`.
- R2: While `avg_en` is 0, `steady` is 1 and `out_data` equals `fir_data` in the same cycle, and `step_det` has no effect.
- R3: A clock edge with `avg_en`=1 and `step_det`=1 enters averaging. From the next cycle `steady` is 0, and `out_data` is the average, which is 0 before any sample has arrived.
- R4: The sample history is all zeros on entry. The first post-step sample `s0` therefore gives `out_data` = `s0 >>> 1`.
- R5: With `n` post-step samples, the window is 2 for n < 4, 4 for 4 ≤ n < 8, 8 for 8 ≤ n < 16, and 16 for n ≥ 16. It stays at 16 until averaging ends.
- R6: `out_data` is the two's-complement sum of the newest window-length samples, shifted arithmetically right by log2 of the window (rounding toward minus infinity). Slots not yet filled count as zero.
- R7: A clock edge in averaging with `fir_settled`=1 and `step_det`=0 ends averaging. From the next cycle `steady` is 1 and `out_data` equals `fir_data`.
- R8: A step detected during averaging clears the history and the sample count, so the window restarts at 2.
- R9: A sample presented on the same edge as a step is discarded.
- R10: Dropping `avg_en` during averaging returns `out_data` to `fir_data` and raises `steady` in the same cycle. Averaging is also abandoned: raising `avg_en` again without a step leaves `steady` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| avg_en | input | 1 | Enables step-triggered averaging |
| step_det | input | 1 | One-cycle strobe: input step detected |
| fir_settled | input | 1 | FIR path has fully settled |
| smp_valid | input | 1 | `smp_data` carries a first-stage sample this cycle |
| smp_data | input | DW | First-stage sample, signed |
| fir_data | input | DW | FIR path result, signed |
| out_data | output | DW | Selected result word, signed |
| steady | output | 1 | 1 when the FIR result is being reported |

## Verification
The properties assume that `fir_settled` is low on the edge where a step is flagged. A settled flag left high from before the step would end averaging one cycle later, and a correct design would then look like a fault. The stimulus always drops `fir_settled` before it raises `step_det`, and raises it again only after the averaging sequence it wants to observe. Samples are presented one per strobed cycle, and their values stay within the signed word, so the 16-sample sums never approach the accumulator width.

// File: rtl/step_avg_filter.sv
module step_avg_filter #(
  parameter int DW    = 16,
  parameter int LGMAX = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 avg_en,
  input  logic                 step_det,
  input  logic                 fir_settled,
  input  logic                 smp_valid,
  input  logic signed [DW-1:0] smp_data,
  input  logic signed [DW-1:0] fir_data,
  output logic signed [DW-1:0] out_data,
  output logic                 steady
);
  localparam int DEPTH = 1 << LGMAX;
  localparam int SW    = DW + LGMAX;
  localparam int CW    = LGMAX + 1;

  logic                 mode_q;
  logic [CW-1:0]        cnt_q;
  logic signed [DW-1:0] hist_q [DEPTH];
  logic signed [SW-1:0] sum_q  [1:LGMAX];
  logic signed [SW-1:0] avg_full;
  int                   lg;

  always_comb begin
    lg = 1;
    for (int k = 2; k <= LGMAX; k++)
      if (int'(cnt_q) >= (1 << k)) lg = k;
    avg_full = sum_q[lg] >>> lg;
  end

  assign steady   = !(avg_en && mode_q);
  assign out_data = steady ? fir_data : avg_full[DW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n || (avg_en && step_det)) begin
      mode_q <= rst_n;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
      for (int k = 1; k <= LGMAX; k++) sum_q[k] <= '0;
    end else if (!avg_en) begin
      mode_q <= 1'b0;
    end else if (mode_q) begin
      if (fir_settled) begin
        mode_q <= 1'b0;
      end else if (smp_valid) begin
        hist_q[0] <= smp_data;
        for (int i = 1; i < DEPTH; i++) hist_q[i] <= hist_q[i-1];
        for (int k = 1; k <= LGMAX; k++)
          sum_q[k] <= sum_q[k] + SW'(smp_data) - SW'(hist_q[(1 << k) - 1]);
        if (int'(cnt_q) < DEPTH) cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

module step_avg_filter_chk #(
  parameter int DW = 16,
  parameter int CW = 5,
  parameter int DEPTH = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 avg_en,
  input logic                 step_det,
  input logic                 fir_settled,
  input logic                 smp_valid,
  input logic signed [DW-1:0] fir_data,
  input logic signed [DW-1:0] out_data,
  input logic                 steady,
  input logic                 mode_q,
  input logic [CW-1:0]        cnt_q
);
  // R2
  en_off_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !avg_en |-> (steady && out_data == fir_data));

  // R3
  step_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (avg_en && step_det) |=> (!avg_en || !steady));

  // R8
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (avg_en && step_det) |=> (cnt_q == '0));

  // R7
  settle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (avg_en && !step_det && mode_q && fir_settled) |=> steady);

  // R5
  fill_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (avg_en && !step_det && mode_q && !fir_settled && smp_valid && int'(cnt_q) < DEPTH)
      |=> (int'(cnt_q) == int'($past(cnt_q)) + 1));

  // R5
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (avg_en && !step_det && mode_q && !smp_valid) |=> $stable(cnt_q));
endmodule

bind step_avg_filter step_avg_filter_chk #(.DW(DW), .CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .avg_en(avg_en), .step_det(step_det),
  .fir_settled(fir_settled), .smp_valid(smp_valid), .fir_data(fir_data),
  .out_data(out_data), .steady(steady), .mode_q(mode_q), .cnt_q(cnt_q)
);

// File: tb/step_avg_filter_tb.sv
`timescale 1ns/1ps
module step_avg_filter_tb;
  localparam int DW = 16;
  localparam int NV = 20;
  localparam logic signed [DW-1:0] VEC [NV] = '{
    16'sd100, 16'sd301, -16'sd7, 16'sd45, 16'sd1000, -16'sd999, 16'sd12, 16'sd13,
    16'sd2047, 16'sd5, -16'sd300, 16'sd77, 16'sd0, 16'sd31, -16'sd1, 16'sd600,
    16'sd250, -16'sd4000, 16'sd9, 16'sd1234};

  logic clk = 0, rst_n = 0, avg_en = 0, step_det = 0, fir_settled = 0, smp_valid = 0;
  logic signed [DW-1:0] smp_data = '0, fir_data = 16'sh1234;
  logic signed [DW-1:0] out_data;
  logic steady;
  int checks = 0, errors = 0;
  int mh [16];
  int mc = 0;

  always #2.5 clk = ~clk;

  step_avg_filter u_dut (
    .clk(clk), .rst_n(rst_n), .avg_en(avg_en), .step_det(step_det),
    .fir_settled(fir_settled), .smp_valid(smp_valid), .smp_data(smp_data),
    .fir_data(fir_data), .out_data(out_data), .steady(steady));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic m_clear();
    for (int i = 0; i < 16; i++) mh[i] = 0;
    mc = 0;
  endtask

  task automatic m_push(input int v);
    for (int i = 15; i > 0; i--) mh[i] = mh[i-1];
    mh[0] = v;
    if (mc < 16) mc++;
  endtask

  function automatic int m_exp();
    int n, s;
    n = (mc >= 16) ? 16 : (mc >= 8) ? 8 : (mc >= 4) ? 4 : 2;
    s = 0;
    for (int i = 0; i < n; i++) s += mh[i];
    return s >>> $clog2(n);
  endfunction

  task automatic tick(input logic v, input logic signed [DW-1:0] d,
                      input logic st, input logic fs);
    @(negedge clk);
    smp_valid = v; smp_data = d; step_det = st; fir_settled = fs;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk("R1 steady", steady, 1);
    chk("R1 out", out_data, 16'sh1234);
    @(negedge clk); rst_n = 1;

    // R2: step ignored while disabled
    tick(1, 16'sd50, 1, 0);
    tick(1, 16'sd60, 0, 0);
    chk("R2 steady", steady, 1);
    @(negedge clk); fir_data = -16'sd321; #1;
    chk("R2 out", out_data, -321);

    // R3, R9: enter averaging, coincident sample discarded
    @(negedge clk); avg_en = 1;
    tick(1, 16'sd1000, 1, 0);
    m_clear();
    chk("R3 steady", steady, 0);
    chk("R9 out", out_data, 0);

    // Table walk: R4 first, then R5/R6
    for (int i = 0; i < NV; i++) begin
      tick(1, VEC[i], 0, 0);
      m_push(VEC[i]);
      chk(i == 0 ? "R4 first" : "R5/R6 avg", out_data, m_exp());
      chk("R3 low", steady, 0);
      tick(0, 16'sd0, 0, 0);
      chk("R5 hold", out_data, m_exp());
    end

    // R8: restart during averaging
    tick(0, 16'sd0, 1, 0);
    m_clear();
    chk("R8 cleared", out_data, 0);
    tick(1, 16'sd100, 0, 0);
    chk("R8 win2", out_data, 50);
    tick(1, -16'sd107, 0, 0);
    chk("R8 neg", out_data, -4);

    // R7: switch back once settled
    tick(0, 16'sd0, 0, 1);
    chk("R7 steady", steady, 1);
    @(negedge clk); fir_data = 16'sd777; #1;
    chk("R7 out", out_data, 777);

    // R10: disable mid-averaging
    tick(0, 16'sd0, 1, 0);
    tick(1, 16'sd400, 0, 0);
    chk("R10 pre", steady, 0);
    @(negedge clk); avg_en = 0; #1;
    chk("R10 steady", steady, 1);
    chk("R10 out", out_data, 777);
    @(posedge clk); #1;
    @(negedge clk); avg_en = 1;
    tick(1, 16'sd8, 0, 0);
    chk("R10 abandoned", steady, 1);
    chk("R10 out2", out_data, 777);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule